// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Sequencer

This block sits between one host and a bank of asynchronous-style dynamic memories that share a multiplexed address bus. The host offers read, write or read-modify-write requests with a valid/ready handshake. The block then runs a complete memory cycle on active-low row and column strobes, a write-enable strobe and one chip select per device. It puts the row half of the address on the bus, lowers the row strobe, switches the bus to the column half, lowers the column strobe, and then runs the data phase and the row precharge. Read data comes back on a registered bus together with a one-clock done pulse.

Chip select is decoded late. The row strobe falls before any device is chosen, and the one addressed device is selected only for the time the column strobe is low. A free-running timer asks for a row-only refresh at a fixed interval. That refresh drives the next row from a wrapping counter with the column strobe, write-enable and every chip select high. A waiting refresh is served before a waiting host request, but it never breaks into a cycle that has already started. Every interval is a whole number of clocks set by a parameter.

The controller is a single state machine. States: IDLE, ROW (row address setup, strobes high), RCD (row strobe low, row address held), COL (column address driven, write-enable lowered for writes), CAS (column strobe low, device selected), MOD (write-enable low inside the column strobe for read-modify-write), PRE (all strobes high for the precharge), REF_ROW (refresh row address setup) and REF_RAS (row-only strobe). Transitions: IDLE→REF_ROW when a refresh is pending; IDLE→ROW on an accepted request; ROW→RCD; RCD→COL after RCD_CLK−1 clocks; COL→CAS; CAS→MOD for read-modify-write, or CAS→PRE otherwise, after the column hold time; MOD→PRE after T_WP clocks; PRE→IDLE after T_RP clocks; REF_ROW→REF_RAS; REF_RAS→PRE after T_RAS_MIN clocks.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset every strobe and chip select is high, dram_doe and host_done are low, and host_ready is high.
- R2: host_addr holds the column in bits [COL_W-1:0], the row in the next ROW_W bits and the device number in the top DEV_W bits. dram_ma carries the row when the row strobe falls and the column when the column strobe falls.
- R3: The column strobe falls exactly RCD_CLK clocks after the row strobe falls.
- R4: All chip selects stay high while the column strobe is high. While it is low, exactly the addressed device's select is low.
- R5: For host_cmd 00 (read), write-enable stays high for the whole cycle. host_rdata returns the value the device presents T_CAC clocks after the column strobe falls.
- R6: For host_cmd 01 (write), write-enable is low and dram_doe is high at least one clock before the column strobe falls, and host_wdata is stored at the addressed location.
- R7: For host_cmd 10 (read-modify-write), write-enable is high when the column strobe falls. It then goes low while both strobes are low, with dram_doe already high. The old value is returned and the new value is stored.
- R8: The row strobe stays low at least T_RAS_MIN clocks and the column strobe at least T_CAS_MIN clocks. The column strobe is low only while the row strobe is low.
- R9: The row strobe stays high at least T_RP clocks before it falls again.
- R10: Every REF_PERIOD clocks a row-only refresh runs. The column strobe, write-enable and all chip selects stay high, and dram_ma carries a row counter that starts at 0 and steps by one modulo 2^ROW_W.
- R11: A pending refresh is started before a host request that is already waiting, and host_ready is low while any cycle is running. Refreshes keep their period under continuous host demand.
- R12: A request is taken once, on a clock where host_valid and host_ready are both high. Changing or dropping the inputs afterwards does not alter or shorten the cycle, and host_done is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller can accept a request this clock |
| host_cmd | input | 2 | 00 read, 01 write, 10 read-modify-write |
| host_addr | input | DEV_W+ROW_W+COL_W | Device, row, column |
| host_wdata | input | DATA_W | Data to write |
| host_rdata | output | DATA_W | Data read from the device |
| host_done | output | 1 | One-clock end-of-request pulse |
| dram_ma | output | MA_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_cs_n | output | 2^DEV_W | Per-device chip select, active low |
| dram_dout | output | DATA_W | Data toward the devices |
| dram_doe | output | 1 | Drive enable for dram_dout |
| dram_din | input | DATA_W | Data from the devices |

## Verification
The hardest case to reach is a refresh that comes due while a host request is already waiting. Both are then eligible in IDLE, and a wrong priority would starve one of them. The bench does not try to time this. It issues back-to-back requests over every address of a small configuration for many refresh periods, so the request line is high at almost every refresh tick. A port monitor then counts refreshes that started while a request was waiting and checks every interval between refreshes. The read-modify-write window, where write-enable falls inside a still-low column strobe, is reached by sweeping that command over all addresses. Each result is compared against a shadow memory kept in the bench.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_RMW   = 2'b10,
        CMD_RSVD  = 2'b11
    } host_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_MOD,
        ST_PRE,
        ST_REF_ROW,
        ST_REF_RAS
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_step_cnt.sv
module dram_step_cnt #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Clocks spent in the current state; cleared on every state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned PERIOD = 781,
    parameter int unsigned ROW_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             adv,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int unsigned PER_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PER_W-1:0] tmr;
    logic             tick;

    assign tick = (tmr == PER_W'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tmr <= '0;
        else if (tick) tmr <= '0;
        else           tmr <= tmr + 1'b1;
    end

    // A new tick wins over an acknowledge in the same clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= tick | (pending & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int unsigned ROW_W      = 6,
    parameter int unsigned COL_W      = 6,
    parameter int unsigned DEV_W      = 1,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned MA_W       = (ROW_W > COL_W) ? ROW_W : COL_W,
    parameter int unsigned RCD_CLK    = 3,
    parameter int unsigned T_CAC      = 5,
    parameter int unsigned T_CAS_MIN  = 5,
    parameter int unsigned T_RAS_MIN  = 8,
    parameter int unsigned T_RP       = 3,
    parameter int unsigned T_WP       = 2,
    parameter int unsigned REF_PERIOD = 781
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_valid,
    output logic                         host_ready,
    input  logic [1:0]                   host_cmd,
    input  logic [DEV_W+ROW_W+COL_W-1:0] host_addr,
    input  logic [DATA_W-1:0]            host_wdata,
    output logic [DATA_W-1:0]            host_rdata,
    output logic                         host_done,
    output logic [MA_W-1:0]              dram_ma,
    output logic                         dram_ras_n,
    output logic                         dram_cas_n,
    output logic                         dram_we_n,
    output logic [(1<<DEV_W)-1:0]        dram_cs_n,
    output logic [DATA_W-1:0]            dram_dout,
    output logic                         dram_doe,
    input  logic [DATA_W-1:0]            dram_din
);
    localparam int unsigned NDEV     = 1 << DEV_W;
    localparam int unsigned RAS_REST = (T_RAS_MIN > RCD_CLK) ? (T_RAS_MIN - RCD_CLK) : 1;
    localparam int unsigned CAS_HOLD = max2(max2(T_CAC, T_CAS_MIN), RAS_REST);
    localparam int unsigned LONGEST  = max2(max2(CAS_HOLD, T_RAS_MIN),
                                            max2(max2(T_RP, T_WP), RCD_CLK));
    localparam int unsigned CNT_W    = $clog2(LONGEST + 1);

    seq_state_e        st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic              ref_pend, ref_ack, ref_adv;
    logic [ROW_W-1:0]  ref_row;

    host_cmd_e         req_cmd;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic [DEV_W-1:0]  req_dev;
    logic [DATA_W-1:0] req_wdata;
    logic              accept;
    logic              is_wr, is_rmw;
    logic [NDEV-1:0]   dev_sel;

    assign accept  = (st == ST_IDLE) && !ref_pend && host_valid;
    assign ref_ack = (st == ST_IDLE) && ref_pend;
    assign ref_adv = (st == ST_REF_RAS) && (st_nx == ST_PRE);
    assign is_wr   = (req_cmd == CMD_WRITE);
    assign is_rmw  = (req_cmd == CMD_RMW);

    dram_step_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_nx != st),
        .cnt   (cnt)
    );

    dram_refresh_sched #(.PERIOD(REF_PERIOD), .ROW_W(ROW_W)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .adv     (ref_adv),
        .pending (ref_pend),
        .row     (ref_row)
    );

    // Request register: loaded once at acceptance, held for the whole cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_cmd   <= CMD_READ;
            req_row   <= '0;
            req_col   <= '0;
            req_dev   <= '0;
            req_wdata <= '0;
        end else if (accept) begin
            req_cmd   <= host_cmd_e'(host_cmd);
            req_col   <= host_addr[COL_W-1:0];
            req_row   <= host_addr[COL_W +: ROW_W];
            req_dev   <= host_addr[COL_W+ROW_W +: DEV_W];
            req_wdata <= host_wdata;
        end
    end

    // Next-state logic.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (ref_pend)        st_nx = ST_REF_ROW;
                        else if (host_valid) st_nx = ST_ROW;
            ST_ROW:     st_nx = ST_RCD;
            ST_RCD:     if (cnt == CNT_W'(RCD_CLK - 2)) st_nx = ST_COL;
            ST_COL:     st_nx = ST_CAS;
            ST_CAS:     if (cnt == CNT_W'(CAS_HOLD - 1)) st_nx = is_rmw ? ST_MOD : ST_PRE;
            ST_MOD:     if (cnt == CNT_W'(T_WP - 1))     st_nx = ST_PRE;
            ST_PRE:     if (cnt == CNT_W'(T_RP - 1))     st_nx = ST_IDLE;
            ST_REF_ROW: st_nx = ST_REF_RAS;
            ST_REF_RAS: if (cnt == CNT_W'(T_RAS_MIN - 1)) st_nx = ST_PRE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Device decode, applied only while the column strobe is low.
    always_comb begin
        for (int i = 0; i < NDEV; i++) dev_sel[i] = (req_dev == DEV_W'(i));
    end

    // Strobe and bus outputs.
    always_comb begin
        host_ready = 1'b0;
        dram_ma    = MA_W'(req_row);
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_cs_n  = '1;
        dram_doe   = 1'b0;
        dram_dout  = req_wdata;
        unique case (st)
            ST_IDLE:    host_ready = !ref_pend;
            ST_ROW:     dram_ma = MA_W'(req_row);
            ST_RCD: begin
                dram_ma    = MA_W'(req_row);
                dram_ras_n = 1'b0;
            end
            ST_COL: begin
                dram_ma    = MA_W'(req_col);
                dram_ras_n = 1'b0;
                dram_we_n  = !is_wr;
                dram_doe   = is_wr;
            end
            ST_CAS: begin
                dram_ma    = MA_W'(req_col);
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_cs_n  = ~dev_sel;
                dram_we_n  = !is_wr;
                dram_doe   = is_wr;
            end
            ST_MOD: begin
                dram_ma    = MA_W'(req_col);
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_cs_n  = ~dev_sel;
                dram_we_n  = 1'b0;
                dram_doe   = 1'b1;
            end
            ST_PRE:     dram_ma = MA_W'(req_col);
            ST_REF_ROW: dram_ma = MA_W'(ref_row);
            ST_REF_RAS: begin
                dram_ma    = MA_W'(ref_row);
                dram_ras_n = 1'b0;
            end
            default: ;
        endcase
    end

    // Read capture at the access count, done when the data phase ends.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
            host_done  <= 1'b0;
        end else begin
            if (st == ST_CAS && cnt == CNT_W'(T_CAC - 1)) host_rdata <= dram_din;
            host_done <= (st_nx == ST_PRE) && (st == ST_CAS || st == ST_MOD);
        end
    end
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int unsigned RCD_CLK   = 3,
    parameter int unsigned T_RAS_MIN = 8,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned NDEV      = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [NDEV-1:0] cs_n,
    input logic            doe,
    input logic            ready,
    input logic            done
);
    logic [15:0] lo_cnt, hi_cnt;

    // Saturating counts of clocks spent low and high on the row strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '1;
        end else begin
            lo_cnt <= ras_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
            hi_cnt <= !ras_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
        end
    end

    p_rcd_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> lo_cnt == 16'(RCD_CLK));
    p_ras_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> lo_cnt >= 16'(T_RAS_MIN));
    p_cas_in_ras_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt >= 16'(T_RP));
    p_cs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |-> &cs_n);
    p_cs_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> $countones(~cs_n) == 1);
    p_we_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(we_n) == 1'b0) && doe);
    p_rmw_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(we_n) && !cas_n) |-> doe && !ras_n);
    p_done_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ras_n && cas_n);
endmodule

bind dram_seq_ctrl dram_seq_chk #(
    .RCD_CLK   (RCD_CLK),
    .T_RAS_MIN (T_RAS_MIN),
    .T_RP      (T_RP),
    .NDEV      (1 << DEV_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (dram_ras_n),
    .cas_n (dram_cas_n),
    .we_n  (dram_we_n),
    .cs_n  (dram_cs_n),
    .doe   (dram_doe),
    .ready (host_ready),
    .done  (host_done)
);

// File: tb/sim_dram_seq_ctrl.sv
module sim_dram_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 4, COL_W = 3, DEV_W = 1, DATA_W = 8, MA_W = 4;
    localparam int RCD_CLK = 3, T_CAC = 2, T_CAS_MIN = 3, T_RAS_MIN = 6;
    localparam int T_RP = 2, T_WP = 2, REF_PERIOD = 300;
    localparam int NLOC = 1 << (DEV_W + ROW_W + COL_W);

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_valid = 1'b0, host_ready, host_done;
    logic [1:0] host_cmd = 2'b00;
    logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
    logic [MA_W-1:0] dram_ma;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_doe;
    logic [1:0] dram_cs_n;
    logic [7:0] dram_dout, dram_din = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DEV_W(DEV_W), .DATA_W(DATA_W),
        .RCD_CLK(RCD_CLK), .T_CAC(T_CAC), .T_CAS_MIN(T_CAS_MIN), .T_RAS_MIN(T_RAS_MIN),
        .T_RP(T_RP), .T_WP(T_WP), .REF_PERIOD(REF_PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_cmd(host_cmd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_done(host_done), .dram_ma(dram_ma),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_cs_n(dram_cs_n), .dram_dout(dram_dout), .dram_doe(dram_doe),
        .dram_din(dram_din));

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Device model memory and the bench's independent shadow of expected contents.
    logic [7:0] mem    [NLOC];
    logic [7:0] shadow [NLOC];

    // Port monitor state.
    int cyc = 0, ras_lo = 0, ras_hi = 1000, cas_lo = 0, ras_fall_cyc = 0;
    int last_ref = 0, ref_count = 0, ref_waiting = 0, done_count = 0, exp_ref = 0;
    logic [3:0] ras_row, cas_col;
    logic [1:0] cas_cs;
    logic cas_seen, we_low_seen, cs_early, we_at_cas, we_before, doe_before;
    logic rmw_fell, rmw_ok, waiting_valid, cur_dev;
    int rcd_meas;
    logic p_ras = 1, p_cas = 1, p_we = 1, p_doe = 0, p_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_ras && !dram_ras_n) begin
                chk("R9 precharge clocks >= T_RP", 32'(ras_hi >= T_RP), 1);
                ras_row = dram_ma; ras_lo = 0; ras_fall_cyc = cyc;
                cas_seen = 0; we_low_seen = 0; cs_early = 0; rmw_fell = 0; rmw_ok = 0;
                waiting_valid = host_valid;
            end
            if (!dram_ras_n) begin
                ras_lo++;
                if (!dram_we_n) we_low_seen = 1;
                if (dram_cas_n && !(&dram_cs_n)) cs_early = 1;
            end else ras_hi++;
            if (p_cas && !dram_cas_n) begin
                cas_seen = 1; cas_col = dram_ma; cas_cs = dram_cs_n; cas_lo = 0;
                we_at_cas = dram_we_n; we_before = p_we; doe_before = p_doe;
                rcd_meas = cyc - ras_fall_cyc;
                cur_dev = (dram_cs_n == 2'b01);
                if (dram_we_n) dram_din = mem[{cur_dev, ras_row[3:0], cas_col[2:0]}];
            end
            if (!dram_cas_n) begin
                cas_lo++;
                if (p_we && !dram_we_n) begin rmw_fell = 1; rmw_ok = dram_doe && !dram_ras_n; end
                if (!dram_we_n && dram_doe) mem[{cur_dev, ras_row[3:0], cas_col[2:0]}] = dram_dout;
            end
            if (!p_cas && dram_cas_n)
                chk("R8 column strobe width", 32'(cas_lo >= T_CAS_MIN), 1);
            if (!p_ras && dram_ras_n) begin
                chk("R8 row strobe width", 32'(ras_lo >= T_RAS_MIN), 1);
                ras_hi = 1;
                if (!cas_seen) begin
                    chk("R10 refresh keeps write-enable high", {31'd0, we_low_seen}, 0);
                    chk("R10 refresh row counter", {28'd0, ras_row}, 32'(exp_ref));
                    exp_ref = (exp_ref + 1) % (1 << ROW_W);
                    if (ref_count > 0)
                        chk("R11 refresh interval", 32'((ras_fall_cyc - last_ref >= REF_PERIOD - 16) &&
                                                         (ras_fall_cyc - last_ref <= REF_PERIOD + 16)), 1);
                    else
                        chk("R10 first refresh time", 32'((ras_fall_cyc >= REF_PERIOD) &&
                                                           (ras_fall_cyc <= REF_PERIOD + 16)), 1);
                    last_ref = ras_fall_cyc; ref_count++;
                    if (waiting_valid) ref_waiting++;
                end
            end
            if (!dram_ras_n && dram_cas_n && !cas_seen && ras_lo > 1 && !(&dram_cs_n))
                chk("R10 refresh chip selects high", 0, 1);
            if (host_done) begin
                done_count++;
                if (p_done) chk("R12 done width", 0, 1);
            end
            if (host_ready) chk("R11 ready only when strobes idle", 32'(dram_ras_n && dram_cas_n), 1);
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
            p_doe = dram_doe; p_done = host_done;
        end
    end

    int ops = 0;

    task automatic host_op(input logic [1:0] cmd, input logic [7:0] addr,
                           input logic [7:0] wd, output logic [7:0] rd);
        int w;
        @(negedge clk);
        host_valid = 1; host_cmd = cmd; host_addr = addr; host_wdata = wd;
        w = 0;
        while (!host_ready && w < 500) begin @(negedge clk); w++; end
        @(posedge clk);
        @(negedge clk);
        // R12: withdraw and scramble inputs right after acceptance.
        host_valid = 0; host_addr = ~addr; host_wdata = ~wd; host_cmd = 2'b11;
        ops++;
        w = 0;
        while (!host_done && w < 500) begin @(negedge clk); w++; end
        chk("R12 request completes", 32'(w < 500), 1);
        rd = host_rdata;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic common_checks(input logic [7:0] addr);
        chk("R2 row on address bus at row strobe", {28'd0, ras_row}, {28'd0, addr[6:3]});
        chk("R2 column on address bus at column strobe", {28'd0, cas_col}, {29'd0, addr[2:0]});
        chk("R3 row-to-column delay", 32'(rcd_meas), RCD_CLK);
        chk("R4 addressed select only", {30'd0, cas_cs}, {30'd0, ~(2'b01 << addr[7])});
        chk("R4 no select before column strobe", {31'd0, cs_early}, 0);
    endtask

    task automatic do_read(input logic [7:0] addr);
        logic [7:0] rd;
        host_op(2'b00, addr, 8'h00, rd);
        common_checks(addr);
        chk("R5 write-enable high in read", {31'd0, we_low_seen}, 0);
        chk("R5 read data", {24'd0, rd}, {24'd0, shadow[addr]});
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [7:0] d);
        logic [7:0] rd;
        host_op(2'b01, addr, d, rd);
        common_checks(addr);
        chk("R6 write-enable low before column strobe", {31'd0, we_before}, 0);
        chk("R6 data driven before column strobe", {31'd0, doe_before}, 1);
        shadow[addr] = d;
    endtask

    task automatic do_rmw(input logic [7:0] addr, input logic [7:0] d);
        logic [7:0] rd;
        host_op(2'b10, addr, d, rd);
        common_checks(addr);
        chk("R7 write-enable high at column strobe", {31'd0, we_at_cas}, 1);
        chk("R7 write-enable falls inside strobes with data driven", {30'd0, rmw_fell, rmw_ok}, 3);
        chk("R7 old data returned", {24'd0, rd}, {24'd0, shadow[addr]});
        shadow[addr] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < NLOC; a++) begin
            mem[a] = 8'(a * 37 + 5);
            shadow[a] = 8'(a * 37 + 5);
        end
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {28'd0, dram_ras_n, dram_cas_n, dram_we_n, dram_doe}, 4'b1110);
        chk("R1 reset selects", {30'd0, dram_cs_n}, 2'b11);
        chk("R1 reset host side", {30'd0, host_done, host_ready}, 2'b01);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, host_ready}, 1);
        for (int a = 0; a < NLOC; a++) do_read(8'(a));
        for (int a = 0; a < NLOC; a++) do_write(8'(a), 8'(a) ^ 8'hA5);
        for (int a = 0; a < NLOC; a++) do_read(8'(a));
        for (int a = NLOC - 1; a >= 0; a--) do_rmw(8'(a), 8'(a + 8'h3C));
        for (int a = 0; a < NLOC; a++) do_read(8'(a));
        repeat (20) @(negedge clk);
        chk("R12 one done per request", 32'(done_count), 32'(ops));
        chk("R10 row counter wrapped", 32'(ref_count > (1 << ROW_W)), 1);
        chk("R11 refresh taken over waiting request", 32'(ref_waiting > 0), 1);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule